// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block turns 32-bit device virtual addresses into physical addresses. The page size is fixed at 4 KiB. The translation table is a single flat array in memory that covers the whole 4 GiB virtual space, with one 32-bit descriptor for each page. There is no multi-level walk: the descriptor for a page sits at the table base plus four times the virtual page number.

A client presents a virtual address with a valid/ready handshake. A small fully associative descriptor cache (TLB) inside the block answers repeated pages without going to memory. On a miss the block issues one memory read, waits for the descriptor, and then answers the client. It accepts no new request until that answer is given.

A descriptor whose valid bit is clear, including an all-zero unmapped entry, is a translation fault. The access is redirected to a protect address, the page-aligned faulting address is captured, and an interrupt is raised. No read/write direction is recorded. Software sets the table base and the protect address through a small register port, clears the interrupt there, and can invalidate the cache there.

Top module: `flat_xlate`

## Requirements
- R1: While reset is held and after it is released, req_ready is 1, rsp_valid, mem_req and irq are 0, and the fault-address register (offset 0x008) and the control register (offset 0x00C) read 0.
- R2: A request whose page is not cached raises mem_req for exactly one cycle, in the cycle after acceptance. mem_addr equals the table base plus {va[31:12], 2'b00}. Only one memory read is made per miss.
- R3: A fetched descriptor with bit 1 set is valid. The response comes in the cycle after mem_rsp_valid, with rsp_pa = {desc[31:12], va[11:0]}, rsp_nonsec = desc[3] and rsp_fault = 0, and the page is then cached.
- R4: A fetched descriptor with bit 1 clear (an all-zero entry included) gives rsp_fault = 1, rsp_nonsec = 0 and rsp_pa equal to the protect register. The page is not cached, so a repeat access fetches again.
- R5: A fault sets irq in the same cycle as the faulting response. While irq is clear, the fault also loads the register at offset 0x008 with {va[31:12], 12'h000}. While irq is set, later faults leave that register unchanged. Writing 1 to bit 0 of offset 0x00C clears irq, and bit 0 of that register reads irq.
- R6: A request whose page is cached is answered in the cycle after acceptance with no memory read, using the cached descriptor fields as in R3.
- R7: req_ready is 1 in idle. It is 0 from the cycle after a miss is accepted until the cycle its response is valid.
- R8: Fills go into cache slots in round-robin order, starting at slot 0 after reset or invalidation. With TLB_ENTRIES slots, filling a further page evicts the oldest filled page, and the others still hit.
- R9: Writing 1 to bit 1 of offset 0x00C invalidates every cache entry and resets the fill pointer, so the next access to any page misses.
- R10: The base register (offset 0x000) reads back with bits [1:0] zero. The protect register (offset 0x004) reads back with bits [6:0] zero, which gives it 128-byte alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_pa | output | 32 | Physical address, or protect address on fault |
| rsp_fault | output | 1 | Translation fault flag |
| rsp_nonsec | output | 1 | Non-secure attribute of the page |
| mem_req | output | 1 | Descriptor read request (one cycle) |
| mem_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor read data valid |
| mem_rsp_data | input | 32 | Descriptor read data |
| irq | output | 1 | Fault interrupt, level, held until cleared |

## Verification
The bench builds the block with TLB_ENTRIES = 4. With four slots, a sweep over a dozen pages causes many evictions, so the round-robin order is exercised across several full wraps, and a bench model of slot order can predict every hit and miss. The descriptor of each page is computed from its page number, so valid, invalid-nonzero and all-zero entries, as well as both non-secure settings, recur throughout the sweep. Memory latency also varies by page. The sticky fault-address capture, the interrupt clear and the invalidation are checked between sweeps, as is a change of base register.

// File: rtl/flat_xlate_pkg.sv
// Shared constants and types of the flat page-table translator.
// Assumes 32-bit addresses and a fixed 4 KiB page.
package flat_xlate_pkg;
    localparam int ADDR_W      = 32;
    localparam int PAGE_SHIFT  = 12;
    localparam int VPN_W       = ADDR_W - PAGE_SHIFT;
    localparam int VALID_BIT   = 1;
    localparam int NONSEC_BIT  = 3;
    localparam int PROT_LSBS   = 7;

    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_ISSUE = 2'd1,
        WALK_WAIT  = 2'd2
    } walk_state_t;

    typedef struct packed {
        logic [VPN_W-1:0] ppn;
        logic             nonsec;
    } page_attr_t;
endpackage

// File: rtl/flat_xlate_tlb.sv
// Fully associative descriptor cache with round-robin fill.
// Assumes the caller never fills a page that already hits (fills only follow misses).
module flat_xlate_tlb
    import flat_xlate_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             look_hit,
    output page_attr_t       look_attr,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  page_attr_t       fill_attr,
    input  logic             flush
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [VPN_W-1:0] tag_q  [ENTRIES];
    page_attr_t       attr_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   fill_ptr;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            // Tag compare for one slot.
            assign match[g] = vld_q[g] && (tag_q[g] == look_vpn);

            // Slot storage: written when the pointer selects it during a fill.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[g]  <= 1'b0;
                    tag_q[g]  <= '0;
                    attr_q[g] <= '0;
                end else if (flush) begin
                    vld_q[g]  <= 1'b0;
                end else if (fill_en && fill_ptr == IDX_W'(g)) begin
                    vld_q[g]  <= 1'b1;
                    tag_q[g]  <= fill_vpn;
                    attr_q[g] <= fill_attr;
                end
            end
        end
    endgenerate

    // Merge the attributes of the matching slot.
    always_comb begin
        look_attr = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) look_attr = look_attr | attr_q[i];
        end
    end
    assign look_hit = |match;

    // Round-robin fill pointer, reset by invalidation.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            fill_ptr <= '0;
        end else if (fill_en) begin
            fill_ptr <= (fill_ptr == IDX_W'(ENTRIES - 1)) ? '0 : fill_ptr + 1'b1;
        end
    end

    // A page is never held in two slots at once.
    assert_unique_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/flat_xlate_regs.sv
// Software-visible registers: table base, protect address, fault address, control.
// Assumes word offsets 0x000/0x004/0x008/0x00C; other offsets read 0 and ignore writes.
module flat_xlate_regs
    import flat_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              fault_set,
    input  logic [ADDR_W-1:0] fault_va,
    output logic [ADDR_W-1:0] table_base,
    output logic [ADDR_W-1:0] protect_pa,
    output logic              flush,
    output logic              irq
);
    logic [ADDR_W-1:0] fva_q;
    logic              sel_ok;
    logic [1:0]        sel;

    assign sel_ok = (reg_addr[11:4] == 8'h00) && (reg_addr[1:0] == 2'b00);
    assign sel    = reg_addr[3:2];
    assign flush  = reg_we && sel_ok && sel == 2'd3 && reg_wdata[1];

    // Base and protect registers with their alignment bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            table_base <= '0;
            protect_pa <= '0;
        end else if (reg_we && sel_ok) begin
            if (sel == 2'd0) table_base <= {reg_wdata[ADDR_W-1:2], 2'b00};
            if (sel == 2'd1) protect_pa <= {reg_wdata[ADDR_W-1:PROT_LSBS], {PROT_LSBS{1'b0}}};
        end
    end

    // Interrupt flag and first-fault address capture; a new fault wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq   <= 1'b0;
            fva_q <= '0;
        end else if (fault_set) begin
            irq <= 1'b1;
            if (!irq) fva_q <= fault_va;
        end else if (reg_we && sel_ok && sel == 2'd3 && reg_wdata[0]) begin
            irq <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (sel_ok) begin
            case (sel)
                2'd0:    reg_rdata = table_base;
                2'd1:    reg_rdata = protect_pa;
                2'd2:    reg_rdata = fva_q;
                default: reg_rdata = {{(ADDR_W-1){1'b0}}, irq};
            endcase
        end
    end

    // The captured address is always page aligned.
    assert_fva_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fva_q[PAGE_SHIFT-1:0] == '0);
endmodule

// File: rtl/flat_xlate.sv
// Flat page-table translator top: client handshake, miss walker, cache and registers.
// Assumes one outstanding miss; memory answers each mem_req with one mem_rsp_valid.
module flat_xlate
    import flat_xlate_pkg::*;
#(
    parameter int TLB_ENTRIES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_va,
    output logic        rsp_valid,
    output logic [31:0] rsp_pa,
    output logic        rsp_fault,
    output logic        rsp_nonsec,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        irq
);
    walk_state_t       state;
    logic [ADDR_W-1:0] va_q;
    logic [ADDR_W-1:0] table_base;
    logic [ADDR_W-1:0] protect_pa;
    logic              flush;
    logic              hit;
    page_attr_t        hit_attr;
    logic              accept;
    logic              desc_ok;
    logic              desc_done;
    logic              fault_set;
    page_attr_t        new_attr;
    logic              unused_desc;

    assign req_ready = (state == WALK_IDLE);
    assign accept    = req_valid && req_ready;
    assign mem_req   = (state == WALK_ISSUE);
    assign desc_done = (state == WALK_WAIT) && mem_rsp_valid;
    assign desc_ok   = mem_rsp_data[VALID_BIT];
    assign fault_set = desc_done && !desc_ok;
    assign new_attr  = '{ppn: mem_rsp_data[ADDR_W-1:PAGE_SHIFT], nonsec: mem_rsp_data[NONSEC_BIT]};
    assign unused_desc = ^{mem_rsp_data[PAGE_SHIFT-1:NONSEC_BIT+1], mem_rsp_data[2], mem_rsp_data[0]};

    flat_xlate_tlb #(.ENTRIES(TLB_ENTRIES)) i_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_vpn  (req_va[ADDR_W-1:PAGE_SHIFT]),
        .look_hit  (hit),
        .look_attr (hit_attr),
        .fill_en   (desc_done && desc_ok),
        .fill_vpn  (va_q[ADDR_W-1:PAGE_SHIFT]),
        .fill_attr (new_attr),
        .flush     (flush)
    );

    flat_xlate_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .fault_set  (fault_set),
        .fault_va   ({va_q[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}}),
        .table_base (table_base),
        .protect_pa (protect_pa),
        .flush      (flush),
        .irq        (irq)
    );

    // Walker sequencing: idle, issue one read, wait for the descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= WALK_IDLE;
            va_q     <= '0;
            mem_addr <= '0;
        end else begin
            case (state)
                WALK_IDLE: if (accept && !hit) begin
                    state    <= WALK_ISSUE;
                    va_q     <= req_va;
                    mem_addr <= table_base + {{(ADDR_W-VPN_W-2){1'b0}}, req_va[ADDR_W-1:PAGE_SHIFT], 2'b00};
                end
                WALK_ISSUE: state <= WALK_WAIT;
                WALK_WAIT:  if (mem_rsp_valid) state <= WALK_IDLE;
                default:    state <= WALK_IDLE;
            endcase
        end
    end

    // Response register: loaded by a hit in idle or by the arrival of a descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_pa     <= '0;
            rsp_fault  <= 1'b0;
            rsp_nonsec <= 1'b0;
        end else begin
            rsp_valid <= (accept && hit) || desc_done;
            if (accept && hit) begin
                rsp_pa     <= {hit_attr.ppn, req_va[PAGE_SHIFT-1:0]};
                rsp_fault  <= 1'b0;
                rsp_nonsec <= hit_attr.nonsec;
            end else if (desc_done) begin
                rsp_pa     <= desc_ok ? {new_attr.ppn, va_q[PAGE_SHIFT-1:0]} : protect_pa;
                rsp_fault  <= !desc_ok;
                rsp_nonsec <= desc_ok && new_attr.nonsec;
            end
        end
    end

    assert_miss_fetches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit) |=> mem_req);
    assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);
    assert_fault_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> irq);
    assert_hit_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> (rsp_valid && !mem_req));
endmodule

// File: tb/test_flat_xlate.sv
// Self-checking bench: page sweeps with a round-robin cache model and computed descriptors.
module test_flat_xlate;
    localparam int TLB_N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic        rsp_fault;
    logic        rsp_nonsec;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [19:0] m_tag [TLB_N];
    bit          m_vld [TLB_N];
    int          m_rr;
    logic [31:0] m_base;
    logic [31:0] m_prot;
    logic [31:0] m_fva;
    bit          m_irq;

    flat_xlate #(.TLB_ENTRIES(TLB_N)) i_flat_xlate (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_va(req_va), .rsp_valid(rsp_valid),
        .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_nonsec(rsp_nonsec),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Descriptor of a page: low three page bits pick zero, invalid or valid.
    function automatic logic [31:0] desc_of(input logic [19:0] vpn);
        if (vpn[2:0] == 3'd7) return 32'h0;
        if (vpn[2:0] == 3'd6) return {vpn ^ 20'h3C3C3, 12'h0F8};
        return {vpn ^ 20'hA5A5A, 12'h0F2 | (vpn[0] ? 12'h008 : 12'h000)};
    endfunction

    task automatic model_flush();
        for (int i = 0; i < TLB_N; i++) m_vld[i] = 0;
        m_rr = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, "register read", reg_rdata, exp);
        reg_addr = '0;
    endtask

    // One translation with full expectation from the cache model and descriptor function.
    task automatic xlate(input logic [31:0] va, input string tag);
        logic [19:0] vpn;
        logic [31:0] d;
        logic [31:0] exp_pa;
        bit hit;
        bit ok;
        int lat;
        vpn = va[31:12];
        d = desc_of(vpn);
        ok = d[1];
        hit = 0;
        for (int i = 0; i < TLB_N; i++) if (m_vld[i] && m_tag[i] == vpn) hit = 1;
        lat = int'(vpn % 3);
        @(negedge clk);
        chk(req_ready == 1'b1, "R7", "ready in idle", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_req == !hit, tag, "miss read request", {31'b0, mem_req}, {31'b0, !hit});
        if (mem_req) begin
            chk(mem_addr == m_base + {10'b0, vpn, 2'b00}, "R2", "descriptor address",
                mem_addr, m_base + {10'b0, vpn, 2'b00});
            chk(rsp_valid == 1'b0, "R2", "no early response", {31'b0, rsp_valid}, 32'd0);
            for (int c = 0; c <= lat; c++) begin
                @(negedge clk);
                chk(req_ready == 1'b0, "R7", "ready low during walk", {31'b0, req_ready}, 32'd0);
                chk(mem_req == 1'b0, "R2", "single read pulse", {31'b0, mem_req}, 32'd0);
            end
            mem_rsp_valid = 1'b1; mem_rsp_data = d;
            @(negedge clk);
            mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        end
        exp_pa = ok ? {d[31:12], va[11:0]} : m_prot;
        chk(rsp_valid == 1'b1, hit ? "R6" : "R3", "response valid", {31'b0, rsp_valid}, 32'd1);
        chk(rsp_pa == exp_pa, ok ? (hit ? "R6" : "R3") : "R4", "physical address", rsp_pa, exp_pa);
        chk(rsp_fault == !ok, ok ? "R3" : "R4", "fault flag", {31'b0, rsp_fault}, {31'b0, !ok});
        chk(rsp_nonsec == (ok && d[3]), ok ? "R3" : "R4", "non-secure flag",
            {31'b0, rsp_nonsec}, {31'b0, ok && d[3]});
        if (!hit && ok) begin
            m_tag[m_rr] = vpn; m_vld[m_rr] = 1; m_rr = (m_rr + 1) % TLB_N;
        end
        if (!ok && !m_irq) begin
            m_irq = 1; m_fva = {vpn, 12'h000};
        end
        chk(irq == m_irq, "R5", "interrupt level", {31'b0, irq}, {31'b0, m_irq});
    endtask

    function automatic logic [31:0] va_of(input int k, input int off);
        return {20'h4C000 + 20'(k), 12'(off)};
    endfunction

    initial begin
        model_flush();
        m_base = 0; m_prot = 0; m_fva = 0; m_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready in reset", {31'b0, req_ready}, 32'd1);
        chk({rsp_valid, mem_req, irq} == 3'b000, "R1", "outputs in reset",
            {29'b0, rsp_valid, mem_req, irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({rsp_valid, mem_req, irq, req_ready} == 4'b0001, "R1", "outputs after reset",
            {28'b0, rsp_valid, mem_req, irq, req_ready}, 32'd1);
        rd(12'h008, 32'h0, "R1");
        rd(12'h00C, 32'h0, "R1");

        // Register alignment.
        wr(12'h000, 32'h1040_0003); m_base = 32'h1040_0000;
        rd(12'h000, 32'h1040_0000, "R10");
        wr(12'h004, 32'h0BAD_C0FF); m_prot = 32'h0BAD_C080;
        rd(12'h004, 32'h0BAD_C080, "R10");

        // Round-robin fill order and eviction.
        for (int k = 0; k < 4; k++) xlate(va_of(k, 16 * k + 3), "R8");
        for (int k = 0; k < 4; k++) xlate(va_of(k, 4095 - k), "R6");
        xlate(va_of(4, 12'h7FF), "R8");
        for (int k = 1; k < 4; k++) xlate(va_of(k, 0), "R8");
        xlate(va_of(0, 1), "R8");

        // Invalidation.
        xlate(va_of(1, 2), "R9");
        wr(12'h00C, 32'h2); model_flush();
        xlate(va_of(1, 2), "R9");
        xlate(va_of(1, 5), "R9");

        // Faults, sticky capture, clear, no fill on fault.
        xlate(va_of(7, 12'hABC), "R4");
        rd(12'h008, m_fva, "R5");
        rd(12'h00C, 32'h1, "R5");
        xlate(va_of(6, 12'h123), "R4");
        rd(12'h008, m_fva, "R5");
        xlate(va_of(7, 12'h001), "R4");
        wr(12'h00C, 32'h1); m_irq = 0;
        rd(12'h00C, 32'h0, "R5");
        chk(irq == 1'b0, "R5", "irq cleared", {31'b0, irq}, 32'd0);
        xlate(va_of(14, 12'hFFF), "R4");
        rd(12'h008, m_fva, "R5");
        wr(12'h00C, 32'h1); m_irq = 0;

        // New base takes effect on the next miss.
        wr(12'h000, 32'h2200_0000); m_base = 32'h2200_0000;
        wr(12'h00C, 32'h2); model_flush();

        // Sweep: many pages, several passes, mixed offsets.
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < 12; k++) begin
                xlate(va_of((k * 5 + p) % 12, (k * 12'h1F3 + p) % 4096), "R3");
                if (m_irq) begin
                    rd(12'h008, m_fva, "R5");
                    wr(12'h00C, 32'h1); m_irq = 0;
                end
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule